// File: doc/BRIEF.md
# Pixel Alpha and Channel Modifier

This block is a single pipeline stage for 32-bit ARGB pixels. The pixel word holds alpha in bits [31:24], red in [23:16], green in [15:8] and blue in [7:0]. Each accepted pixel passes through an alpha stage and a channel-order stage. Its modified form appears on the output one clock later.

The alpha stage has four settings. It can keep the incoming alpha, substitute a programmed 8-bit constant, or scale the incoming alpha by the constant over 255 with rounding to nearest. The fourth code is reserved and behaves like keep. An invert flag complements both the incoming alpha and the programmed constant before the selected mode uses them. A swap flag exchanges the red and blue fields.

The configuration is captured together with the pixel, so each pixel uses the settings present when it was accepted. Flow control is a valid/ready pair on each side. The input ready signal follows the downstream ready, so a continuous stream moves at one pixel per clock.

Top module: `pix_alpha_stage`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: With cfgMode = 2'b00, output alpha [31:24] equals the incoming alpha. The reserved code 2'b11 gives the same result.
- R3: With cfgMode = 2'b01, output alpha equals cfgAlpha.
- R4: With cfgMode = 2'b10, output alpha equals round(a*c/255), where a is the incoming alpha and c is the constant. A constant of 255 and an alpha of 255 give 255. Either operand at 0 gives 0.
- R5: With cfgInvert = 1, both the incoming alpha and cfgAlpha are replaced by their bitwise complement before the mode is applied.
- R6: With cfgSwap = 1, output bits [23:16] take input bits [7:0] and output bits [7:0] take input bits [23:16]. Green [15:8] is never altered.
- R7: A pixel accepted at a clock edge (inValid and inReady both high) appears on outPixel with outValid high after that edge. If nothing new is accepted, outValid falls after the edge on which outReady takes the pixel.
- R8: While outValid is 1 and outReady is 0, inReady is 0 and outPixel and outValid hold their values.
- R9: Configuration inputs are sampled only at acceptance. Changing them later does not affect a pixel already held on the output.
- R10: When outReady is 1, a new pixel is accepted on the same edge that the held pixel drains, so a continuous stream has no empty cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Stage can accept a pixel |
| inPixel | input | 32 | Input ARGB pixel |
| cfgMode | input | 2 | Alpha mode: 00 keep, 01 replace, 10 scale, 11 reserved (keep) |
| cfgAlpha | input | 8 | Programmed alpha constant |
| cfgInvert | input | 1 | Complement incoming alpha and constant |
| cfgSwap | input | 1 | Exchange red and blue fields |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts the output pixel |
| outPixel | output | 32 | Modified ARGB pixel |

## Verification
The hardest situation to reach from the ports is a stall with a second pixel already waiting at the input. The downstream side drops ready while a pixel is held, a new pixel and a new configuration are presented, and ready is then released. The stimulus holds ready low for two cycles with the next pixel and changed settings on the inputs. This shows that the held result ignores the new settings, and that the waiting pixel loads on the very edge the held one drains. The scaling rounding is exercised with directed extremes (0, 128, 255) and a few hundred random alpha pairs. These are compared against an integer round-to-nearest model.

// File: rtl/pix_alpha_pkg.sv
package pix_alpha_pkg;

  // Alpha mode encoding seen on cfgMode.
  typedef enum logic [1:0] {
    AM_KEEP    = 2'b00,
    AM_REPLACE = 2'b01,
    AM_SCALE   = 2'b10,
    AM_RSVD    = 2'b11
  } alphaMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
  } dpStrobe_t;

  // Field slots inside a pixel word (channel index times channel width).
  localparam int unsigned SLOT_B = 0;
  localparam int unsigned SLOT_G = 1;
  localparam int unsigned SLOT_R = 2;
  localparam int unsigned SLOT_A = 3;

endpackage

// File: rtl/pix_alpha_ctrl.sv
module pix_alpha_ctrl
  import pix_alpha_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output dpStrobe_t strobe
);

  logic holdValid;

  // Space exists when the slot is empty or is being drained this cycle.
  assign inReady     = outReady || !holdValid;
  assign strobe.load = inValid && inReady;
  assign outValid    = holdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
    end else if (strobe.load) begin
      holdValid <= 1'b1;
    end else if (outReady) begin
      holdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/pix_alpha_dp.sv
module pix_alpha_dp
  import pix_alpha_pkg::*;
#(
  parameter  int unsigned CH_W  = 8,
  localparam int unsigned PIX_W = 4 * CH_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PIX_W-1:0] inPixel,
  input  logic [1:0]       cfgMode,
  input  logic [CH_W-1:0]  cfgAlpha,
  input  logic             cfgInvert,
  input  logic             cfgSwap,
  output logic [PIX_W-1:0] outPixel
);

  localparam int unsigned PROD_W = 2 * CH_W;
  localparam logic [PROD_W:0] HALF = (PROD_W + 1)'(1) << (CH_W - 1);

  // Rounded a*c/(2^CH_W - 1) using a bias and a fold-back of the high part.
  function automatic logic [CH_W-1:0] scaleAlpha(input logic [CH_W-1:0] a,
                                                 input logic [CH_W-1:0] c);
    logic [PROD_W-1:0] prod;
    logic [PROD_W:0]   biased;
    logic [PROD_W:0]   folded;
    prod   = {{CH_W{1'b0}}, a} * {{CH_W{1'b0}}, c};
    biased = {1'b0, prod} + HALF;
    folded = biased + (biased >> CH_W);
    return folded[PROD_W-1:CH_W];
  endfunction

  logic [PIX_W-1:0] nextPixel;
  logic [CH_W-1:0]  srcAlpha;
  logic [CH_W-1:0]  constAlpha;
  alphaMode_e       mode;

  assign srcAlpha   = inPixel[SLOT_A*CH_W +: CH_W] ^ {CH_W{cfgInvert}};
  assign constAlpha = cfgAlpha ^ {CH_W{cfgInvert}};
  assign mode       = alphaMode_e'(cfgMode);

  always_comb begin
    unique case (mode)
      AM_REPLACE: nextPixel[SLOT_A*CH_W +: CH_W] = constAlpha;
      AM_SCALE:   nextPixel[SLOT_A*CH_W +: CH_W] = scaleAlpha(srcAlpha, constAlpha);
      AM_KEEP,
      AM_RSVD:    nextPixel[SLOT_A*CH_W +: CH_W] = srcAlpha;
      default:    nextPixel[SLOT_A*CH_W +: CH_W] = srcAlpha;
    endcase
  end

  // Colour channels: each slot picks its own field or its swap partner.
  for (genvar ch = 0; ch < 3; ch++) begin : g_colour
    localparam int unsigned PARTNER =
      (ch == SLOT_R) ? SLOT_B : ((ch == SLOT_B) ? SLOT_R : ch);
    assign nextPixel[ch*CH_W +: CH_W] =
      cfgSwap ? inPixel[PARTNER*CH_W +: CH_W] : inPixel[ch*CH_W +: CH_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPixel <= '0;
    end else if (strobe.load) begin
      outPixel <= nextPixel;
    end
  end

endmodule

// File: rtl/pix_alpha_stage.sv
module pix_alpha_stage
  import pix_alpha_pkg::*;
#(
  parameter  int unsigned CH_W  = 8,
  localparam int unsigned PIX_W = 4 * CH_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inPixel,
  input  logic [1:0]       cfgMode,
  input  logic [CH_W-1:0]  cfgAlpha,
  input  logic             cfgInvert,
  input  logic             cfgSwap,
  output logic             outValid,
  input  logic             outReady,
  output logic [PIX_W-1:0] outPixel
);

  dpStrobe_t strobe;

  pix_alpha_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  pix_alpha_dp #(.CH_W(CH_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inPixel   (inPixel),
    .cfgMode   (cfgMode),
    .cfgAlpha  (cfgAlpha),
    .cfgInvert (cfgInvert),
    .cfgSwap   (cfgSwap),
    .outPixel  (outPixel)
  );

endmodule

// File: rtl/pix_alpha_stage_chk.sv
module pix_alpha_stage_chk #(
  parameter  int unsigned CH_W  = 8,
  localparam int unsigned PIX_W = 4 * CH_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [PIX_W-1:0] inPixel,
  input logic [1:0]       cfgMode,
  input logic [CH_W-1:0]  cfgAlpha,
  input logic             cfgInvert,
  input logic             cfgSwap,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outPixel
);

  logic accept;
  assign accept = inValid && inReady;

  // R8: a stalled output holds its contents
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPixel)));

  // R8: no space while stalled
  a_r8_no_ready_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R7: accepted pixel is valid next cycle
  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);

  // R7: drained with nothing new leaves the output empty
  a_r7_drain_empties: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !accept) |=> !outValid);

  // R3: replace mode without inversion yields the constant
  a_r3_replace_alpha: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cfgMode == 2'b01 && !cfgInvert) |=>
      (outPixel[PIX_W-1 -: CH_W] == $past(cfgAlpha)));

  // R6: green is never altered
  a_r6_green_kept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (outPixel[2*CH_W-1 -: CH_W] == $past(inPixel[2*CH_W-1 -: CH_W])));

  // R1: empty stage always offers ready
  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

endmodule

bind pix_alpha_stage pix_alpha_stage_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .inPixel   (inPixel),
  .cfgMode   (cfgMode),
  .cfgAlpha  (cfgAlpha),
  .cfgInvert (cfgInvert),
  .cfgSwap   (cfgSwap),
  .outValid  (outValid),
  .outReady  (outReady),
  .outPixel  (outPixel)
);

// File: tb/pix_alpha_stage_test.sv
module pix_alpha_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 11;
  localparam int N_RAND     = 300;

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  alpha;
    logic        inv;
    logic        swap;
    logic [31:0] pix;
    logic [31:0] exp;
  } vec_t;

  // mode, alpha, invert, swap, pixel, expected
  localparam vec_t VECS [N_VEC] = '{
    '{2'd0, 8'h00, 1'b0, 1'b0, 32'h80112233, 32'h80112233}, // R2 keep
    '{2'd1, 8'h5A, 1'b0, 1'b0, 32'h80112233, 32'h5A112233}, // R3 replace
    '{2'd2, 8'hFF, 1'b0, 1'b0, 32'h80112233, 32'h80112233}, // R4 x*255
    '{2'd2, 8'h00, 1'b0, 1'b0, 32'h80112233, 32'h00112233}, // R4 x*0
    '{2'd0, 8'h00, 1'b1, 1'b0, 32'h80112233, 32'h7F112233}, // R5 invert source
    '{2'd0, 8'h00, 1'b0, 1'b1, 32'h80112233, 32'h80332211}, // R6 swap
    '{2'd1, 8'h5A, 1'b1, 1'b0, 32'h80112233, 32'hA5112233}, // R5 invert constant
    '{2'd3, 8'h12, 1'b0, 1'b0, 32'h80112233, 32'h80112233}, // R2 reserved
    '{2'd2, 8'hFF, 1'b0, 1'b0, 32'hFFAABBCC, 32'hFFAABBCC}, // R4 255*255
    '{2'd2, 8'h80, 1'b0, 1'b0, 32'h80112233, 32'h40112233}, // R4 rounding
    '{2'd2, 8'h00, 1'b1, 1'b1, 32'h80112233, 32'h7F332211}  // R5 R6 combined
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inPixel = '0;
  logic [1:0]  cfgMode = '0;
  logic [7:0]  cfgAlpha = '0;
  logic        cfgInvert = 1'b0;
  logic        cfgSwap = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outPixel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_alpha_stage uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPixel(inPixel), .cfgMode(cfgMode), .cfgAlpha(cfgAlpha),
    .cfgInvert(cfgInvert), .cfgSwap(cfgSwap), .outValid(outValid),
    .outReady(outReady), .outPixel(outPixel)
  );

  function automatic logic [31:0] refPix(input logic [1:0] m, input logic [7:0] c,
                                         input logic inv, input logic sw,
                                         input logic [31:0] p);
    int a, k, res;
    a = inv ? (255 - int'(p[31:24])) : int'(p[31:24]);
    k = inv ? (255 - int'(c)) : int'(c);
    case (m)
      2'd1:    res = k;
      2'd2:    res = (2 * a * k + 255) / 510;
      default: res = a;
    endcase
    return {res[7:0], sw ? p[7:0] : p[23:16], p[15:8], sw ? p[23:16] : p[7:0]};
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one beat at a falling edge; return at the next falling edge,
  // by which time the accepted result sits on the output.
  task automatic sendBeat(input logic [1:0] m, input logic [7:0] c, input logic inv,
                          input logic sw, input logic [31:0] p);
    @(negedge clk);
    cfgMode = m; cfgAlpha = c; cfgInvert = inv; cfgSwap = sw; inPixel = p;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    checkEq("R1 inReady after reset", {31'd0, inReady}, 32'd1);

    // Table walk: R2..R7
    for (int i = 0; i < N_VEC; i++) begin
      sendBeat(VECS[i].mode, VECS[i].alpha, VECS[i].inv, VECS[i].swap, VECS[i].pix);
      checkEq("R7 outValid after accept", {31'd0, outValid}, 32'd1);
      checkEq($sformatf("R2-R6 vector %0d", i), outPixel, VECS[i].exp);
    end
    @(negedge clk);
    checkEq("R7 outValid after drain", {31'd0, outValid}, 32'd0);

    // R9: changing config after acceptance leaves the result alone
    outReady = 1'b0;
    sendBeat(2'd0, 8'h00, 1'b0, 1'b0, 32'h80112233);
    cfgMode = 2'd1; cfgAlpha = 8'h00; cfgInvert = 1'b1; cfgSwap = 1'b1;
    @(negedge clk);
    checkEq("R9 held pixel ignores new config", outPixel, 32'h80112233);

    // R8 stall with a waiting pixel, then R10 no bubble on release
    inPixel = 32'h40010203; cfgMode = 2'd1; cfgAlpha = 8'h00;
    cfgInvert = 1'b0; cfgSwap = 1'b0; inValid = 1'b1;
    #1;
    checkEq("R8 inReady low while stalled", {31'd0, inReady}, 32'd0);
    @(negedge clk);
    checkEq("R8 outPixel held", outPixel, 32'h80112233);
    checkEq("R8 outValid held", {31'd0, outValid}, 32'd1);
    outReady = 1'b1;
    #1;
    checkEq("R10 inReady follows outReady", {31'd0, inReady}, 32'd1);
    @(negedge clk);
    inValid = 1'b0;
    checkEq("R10 next pixel without bubble", outPixel, 32'h00010203);
    checkEq("R10 outValid stays high", {31'd0, outValid}, 32'd1);
    @(negedge clk);
    checkEq("R7 empty after final drain", {31'd0, outValid}, 32'd0);

    // Random sweep against the integer model: R2 R3 R4 R5 R6
    for (int n = 0; n < N_RAND; n++) begin
      logic [1:0]  m;
      logic [7:0]  c;
      logic [31:0] p;
      logic        inv, sw;
      m = 2'($urandom_range(0, 3));
      c = 8'($urandom);
      p = $urandom;
      inv = 1'($urandom);
      sw = 1'($urandom);
      if (n % 8 == 0) c = 8'hFF;
      if (n % 8 == 1) c = 8'h00;
      if (n % 8 == 2) p[31:24] = 8'hFF;
      if (n % 8 == 3) p[31:24] = 8'h00;
      sendBeat(m, c, inv, sw, p);
      checkEq($sformatf("R4 random mode %0d", m), outPixel, refPix(m, c, inv, sw, p));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule